// File: doc/BRIEF.md
# Three-Wire Serial Control Register Target

This block is the serial control port of a display driver chip. A host talks to it over three wires: an active-low select, a serial clock and one shared data line. The shared line appears at the block as a separate input, output and output-enable, and the pad ring combines them. Each transfer starts with a 7-bit header, sent most significant bit first: a 6-bit register index and then a direction bit. A write continues with one padding bit and eight data bits. A read spends one clock with nobody driving the line and then returns eight data bits from the target.

Four registers sit behind the port:
- **0x00** is a free scratch byte that the host uses to check the link.
- **0x01** is a fixed identity byte. The chip number is in the high nibble and the revision in the low nibble.
- **0x02** holds a 3-bit panel resolution code.
- **0x03** holds a run/standby bit and a bit that hands control of resolution and standby to software.

While software has not taken control, the resolution and run outputs to the rest of the chip come from strap pins.

The serial inputs are treated as asynchronous. They are synchronised into the system clock domain, and edges of the serial clock are detected there. The serial clock must therefore be several times slower than the system clock.

Top module: `spi3w_panel_slave`

## Requirements
- R1: Each frame is sent most significant bit first on rising serial clock edges. Bits 1 to 6 are the register index. Bit 7 is the direction: 1 means read, 0 means write.
- R2: On a write, bit 8 is padding and has no effect, whether it is 0 or 1. Bits 9 to 16 are the data. The register updates only after the 16th rising edge.
- R3: On a read, the data line enable stays low through the 8th clock. After the 8th falling edge the target drives 8 data bits, most significant first, and changes them only after falling edges. The enable drops again after the 16th falling edge.
- R4: Register 0x00 reads back exactly the last value written to it. Its reset value is 0x00.
- R5: Register 0x01 always reads {CHIP_ID, CHIP_VER}, which is 0x13 with the default parameters. Writes to it have no effect.
- R6: Register 0x02 stores bits 2:0 as the resolution code, and its upper bits read 0. Its reset value is 0x07.
- R7: Register 0x03 stores bit 0 (run, where 1 means active) and bit 7 (software control). Its other bits read 0, and its reset value is 0x00.
- R8: While bit 7 of register 0x03 is 0, the outputs `res_code` and `panel_active` follow `strap_res` and `strap_active`. While that bit is 1, they follow register 0x02 bits 2:0 and register 0x03 bit 0. The outputs are registered, so each follows its source one clock later.
- R9: Raising the select before the 16th rising edge abandons the frame, and no register changes. The next frame starts again at bit 1.
- R10: Register indices 0x04 to 0x3F read 0x00, and writes to them have no effect.
- R11: After reset the data line enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| sd_in | input | 1 | Shared data line, as seen at the input buffer |
| sd_out | output | 1 | Data driven onto the shared line |
| sd_oe | output | 1 | Enable for the shared data line driver |
| strap_res | input | 3 | Resolution code from the strap pins |
| strap_active | input | 1 | Run/standby level from the strap pin |
| res_code | output | 3 | Resolution code in effect |
| panel_active | output | 1 | 1 = panel running, 0 = standby |

## Verification
The assertions assume the following about the host:
- Each serial clock level lasts longer than the synchroniser delay, so every edge is seen exactly once.
- The data line is stable around each rising edge.
- The select changes only while the serial clock is low.

The bench drives every pin on the falling system clock edge and holds each serial clock level for six system clocks. It only moves the select with the serial clock low. Under these assumptions the assertions can relate the driver enable, the write strobe and the output selection directly to the detected serial clock edges.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int HDR_BITS   = ADDR_W + 1;
  localparam int FRAME_BITS = HDR_BITS + 1 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int RES_W      = 3;

  localparam logic [ADDR_W-1:0] IDX_SCRATCH = 6'h00;
  localparam logic [ADDR_W-1:0] IDX_IDENT   = 6'h01;
  localparam logic [ADDR_W-1:0] IDX_RES     = 6'h02;
  localparam logic [ADDR_W-1:0] IDX_CTL     = 6'h03;

  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_SW_BIT  = 7;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
  import spi3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sck_rise,
  output logic              sck_fall,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sd_out,
  output logic              sd_oe
);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] DRV_AT   = CNT_W'(HDR_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);

  logic              sck_d;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_BITS-1:0] hdr;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic              is_read;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign is_read  = hdr[0];
  assign rd_addr  = hdr[HDR_BITS-1:1];
  assign sd_out   = dout[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      cnt     <= '0;
      hdr     <= '0;
      din     <= '0;
      dout    <= '0;
      sd_oe   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!cs_act) begin
      cnt   <= '0;
      sd_oe <= 1'b0;
    end else begin
      if (sck_rise && cnt < FULL) begin
        cnt <= cnt + 1'b1;
        if (cnt < HDR_END) hdr <= {hdr[HDR_BITS-2:0], sdi_s};
        if (cnt > HDR_END) din <= {din[DATA_W-2:0], sdi_s};
        if (cnt == LAST_BIT && !is_read) begin
          wr_en   <= 1'b1;
          wr_addr <= hdr[HDR_BITS-1:1];
          wr_data <= {din[DATA_W-2:0], sdi_s};
        end
      end
      if (sck_fall && is_read) begin
        if (cnt == DRV_AT) begin
          sd_oe <= 1'b1;
          dout  <= rd_data;
        end else if (cnt == FULL) begin
          sd_oe <= 1'b0;
        end else if (sd_oe) begin
          dout <= {dout[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
  import spi3w_pkg::*;
#(
  parameter logic [3:0]       CHIP_ID  = 4'h1,
  parameter logic [3:0]       CHIP_VER = 4'h3,
  parameter logic [RES_W-1:0] RES_RST  = 3'b111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [RES_W-1:0]  res_reg,
  output logic              act_reg,
  output logic              sw_ctl
);
  logic [DATA_W-1:0] scratch;

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch <= '0;
      res_reg <= RES_RST;
      act_reg <= 1'b0;
      sw_ctl  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        IDX_SCRATCH: scratch <= wr_data;
        IDX_RES:     res_reg <= wr_data[RES_W-1:0];
        IDX_CTL: begin
          act_reg <= wr_data[CTL_RUN_BIT];
          sw_ctl  <= wr_data[CTL_SW_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      IDX_SCRATCH: rd_data = scratch;
      IDX_IDENT:   rd_data = {CHIP_ID, CHIP_VER};
      IDX_RES:     rd_data[RES_W-1:0] = res_reg;
      IDX_CTL: begin
        rd_data[CTL_RUN_BIT] = act_reg;
        rd_data[CTL_SW_BIT]  = sw_ctl;
      end
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spi3w_panel_slave.sv
module spi3w_panel_slave
  import spi3w_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [3:0]       CHIP_ID     = 4'h1,
  parameter logic [3:0]       CHIP_VER    = 4'h3,
  parameter logic [RES_W-1:0] RES_RST     = 3'b111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sd_in,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic [RES_W-1:0] strap_res,
  input  logic             strap_active,
  output logic [RES_W-1:0] res_code,
  output logic             panel_active
);
  logic [2:0]        sync_q;
  logic              cs_act, sck_s, sdi_s;
  logic              sck_rise, sck_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [RES_W-1:0]  res_reg;
  logic              act_reg, sw_ctl;

  spi3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, sd_in}), .q(sync_q)
  );

  assign cs_act = ~sync_q[2];
  assign sck_s  = sync_q[1];
  assign sdi_s  = sync_q[0];

  spi3w_frame u_frame (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_s(sck_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  spi3w_regs #(.CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER), .RES_RST(RES_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .res_reg(res_reg), .act_reg(act_reg), .sw_ctl(sw_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_code     <= '0;
      panel_active <= 1'b0;
    end else if (sw_ctl) begin
      res_code     <= res_reg;
      panel_active <= act_reg;
    end else begin
      res_code     <= strap_res;
      panel_active <= strap_active;
    end
  end
endmodule

// File: rtl/spi3w_panel_slave_chk.sv
module spi3w_panel_slave_chk
  import spi3w_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cs_act,
  input logic             sck_rise,
  input logic             sck_fall,
  input logic             sd_oe,
  input logic             sd_out,
  input logic             wr_en,
  input logic             sw_ctl,
  input logic [RES_W-1:0] res_reg,
  input logic             act_reg,
  input logic [RES_W-1:0] strap_res,
  input logic             strap_active,
  input logic [RES_W-1:0] res_code,
  input logic             panel_active
);
  // R3: the driver is released once the frame is deselected
  assert_oe_needs_cs_R3: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sd_oe);

  // R3: the driver turns on only after a falling serial clock edge
  assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_oe) |-> $past(sck_fall));

  // R3: driven data changes only after falling edges
  assert_out_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (sd_oe && $past(sd_oe) && !$past(sck_fall)) |-> $stable(sd_out));

  // R2 / R9: a write commits only right after a rising edge inside a selected frame
  assert_wr_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(cs_act) && $past(sck_rise)));

  // R8: hardware control follows the strap pins
  assert_strap_follow_R8: assert property (@(posedge clk) disable iff (rst)
    !sw_ctl |=> (res_code == $past(strap_res) && panel_active == $past(strap_active)));

  // R8: software control follows the registers
  assert_reg_follow_R8: assert property (@(posedge clk) disable iff (rst)
    sw_ctl |=> (res_code == $past(res_reg) && panel_active == $past(act_reg)));

  // R11: driver is off in the first cycle after reset
  assert_reset_oe_R11: assert property (@(posedge clk)
    $past(rst) |-> !sd_oe);
endmodule

bind spi3w_panel_slave spi3w_panel_slave_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .sd_oe(sd_oe), .sd_out(sd_out), .wr_en(wr_en),
  .sw_ctl(sw_ctl), .res_reg(res_reg), .act_reg(act_reg),
  .strap_res(strap_res), .strap_active(strap_active),
  .res_code(res_code), .panel_active(panel_active)
);

// File: tb/spi3w_panel_slave_tb.sv
module spi3w_panel_slave_tb;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sd_in = 1'b0;
  logic       sd_out, sd_oe;
  logic [2:0] strap_res = 3'b101;
  logic       strap_active = 1'b1;
  logic [2:0] res_code;
  logic       panel_active;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi3w_panel_slave u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sd_in(sd_in),
    .sd_out(sd_out), .sd_oe(sd_oe), .strap_res(strap_res),
    .strap_active(strap_active), .res_code(res_code),
    .panel_active(panel_active)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One host frame; stop_at < 16 raises the select early
  task automatic xfer(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                      input bit pad, input int stop_at,
                      output logic [7:0] rdv, output bit ta_z,
                      output bit oe_ok, output bit rel_ok);
    rdv = '0; ta_z = 1'b0; oe_ok = 1'b1; rel_ok = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 16; i++) begin
      if (i == stop_at) break;
      if (i < 6)       sd_in = a[5-i];
      else if (i == 6) sd_in = rd;
      else if (i == 7) sd_in = rd ? 1'b0 : pad;
      else             sd_in = rd ? 1'b0 : wd[15-i];
      wait_clk(HALF);
      if (rd && i == 7) ta_z = !sd_oe;
      if (rd && i >= 8) begin
        rdv[15-i] = sd_out;
        if (!sd_oe) oe_ok = 1'b0;
      end
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    rel_ok = !sd_oe;
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input bit pad);
    logic [7:0] v; bit t, o, r;
    xfer(1'b0, a, d, pad, 16, v, t, o, r);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    bit t, o, r;
    xfer(1'b1, a, 8'h00, 1'b0, 16, v, t, o, r);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R11 oe after reset", {7'b0, sd_oe}, 8'h00);
    check("R8 strap res at reset", {5'b0, res_code}, 8'h05);
    check("R8 strap run at reset", {7'b0, panel_active}, 8'h01);
    rd(6'h02, v); check("R6 res reset value", v, 8'h07);
    rd(6'h03, v); check("R7 ctl reset value", v, 8'h00);
    rd(6'h00, v); check("R4 scratch reset value", v, 8'h00);
  endtask

  task automatic t_turnaround;
    logic [7:0] v; bit t, o, r;
    xfer(1'b1, 6'h01, 8'h00, 1'b0, 16, v, t, o, r);
    check("R1 R5 ident read", v, 8'h13);
    check("R3 line undriven at turnaround", {7'b0, t}, 8'h01);
    check("R3 driven during data bits", {7'b0, o}, 8'h01);
    check("R3 released after frame", {7'b0, r}, 8'h01);
  endtask

  task automatic t_scratch;
    logic [7:0] v;
    wr(6'h00, 8'h55, 1'b0); rd(6'h00, v); check("R4 scratch 0x55", v, 8'h55);
    wr(6'h00, 8'hA5, 1'b1); rd(6'h00, v); check("R2 pad bit ignored", v, 8'hA5);
    wr(6'h00, 8'h01, 1'b0); rd(6'h00, v); check("R1 MSB first lsb only", v, 8'h01);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    wr(6'h01, 8'hFF, 1'b0); rd(6'h01, v); check("R5 ident ignores write", v, 8'h13);
    wr(6'h05, 8'h3C, 1'b0); rd(6'h05, v); check("R10 unmapped reads zero", v, 8'h00);
    rd(6'h00, v); check("R10 unmapped write left scratch", v, 8'h01);
    rd(6'h3F, v); check("R10 top index reads zero", v, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] v; bit t, o, r;
    xfer(1'b0, 6'h00, 8'hEE, 1'b0, 15, v, t, o, r);
    rd(6'h00, v); check("R9 aborted write no effect", v, 8'h01);
    xfer(1'b0, 6'h00, 8'hEE, 1'b0, 4, v, t, o, r);
    wr(6'h00, 8'h3A, 1'b0); rd(6'h00, v); check("R9 counter restarts", v, 8'h3A);
  endtask

  task automatic t_control;
    logic [7:0] v;
    wr(6'h02, 8'hFC, 1'b0);
    rd(6'h02, v); check("R6 res upper bits zero", v, 8'h04);
    check("R8 straps while hw control", {5'b0, res_code}, 8'h05);
    wr(6'h03, 8'hFF, 1'b0);
    rd(6'h03, v); check("R7 ctl stores bits 7 and 0", v, 8'h81);
    check("R8 sw res", {5'b0, res_code}, 8'h04);
    check("R8 sw run", {7'b0, panel_active}, 8'h01);
    wr(6'h03, 8'h80, 1'b0);
    check("R8 sw standby", {7'b0, panel_active}, 8'h00);
    strap_res = 3'b010; wait_clk(3);
    check("R8 straps ignored under sw", {5'b0, res_code}, 8'h04);
    wr(6'h03, 8'h00, 1'b0);
    check("R8 back to straps res", {5'b0, res_code}, 8'h02);
    check("R8 back to straps run", {7'b0, panel_active}, 8'h01);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset;
    t_turnaround;
    t_scratch;
    t_readonly;
    t_abort;
    t_control;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule